// File: doc/BRIEF.md
# Event-Triggered Transfer Injection Sequencer

This block sits next to an in-order instruction pipeline and turns peripheral request pulses into single injected data-transfer slots. Each source has a sticky request flag, an enable bit and a priority level. The block runs one arbitration round per clock among the flagged, enabled sources. When a source wins, the block places a transfer micro-operation into the decode stage for one cycle. While that slot is present the next program instruction is held back. The winner's flag is cleared at the end of that cycle, and normal execution resumes in the following cycle.

Three conditions change the timing. If the instruction in flight reads one of the transfer-channel control registers in the cycle after a source has won, that round is thrown away and run again, so the injection comes one cycle later. After a return from interrupt, a holdoff counter must count down a set number of completed program instructions before a new round may start. A bus-busy input, which stands for external ready or hold delays, freezes the sequencer and the holdoff counter for as long as it is high.

Top module: `xfer_inject_seq`

## Requirements
- R1: A one-cycle pulse on `req_pulse[i]` sets `flags[i]` at the next clock edge, whatever the value of `src_en[i]`. The flag then stays set until that source is serviced.
- R2: With the sequencer idle, no holdoff, `bus_busy` low and `ctl_rd` low, `slot_inject` goes high in the third cycle after the cycle in which the pulse was applied. It stays high for exactly one cycle, and `slot_src` then carries the winning source index.
- R3: `slot_done` is high in the cycle right after `slot_inject` and lasts one cycle. The two outputs are never high together. `slot_inject` high means the next program instruction is stalled.
- R4: A source whose `src_en` bit is 0 never wins, even when its flag is set. It competes as soon as it is enabled.
- R5: The source with the highest `src_prio` value wins. On a tie, the lower index wins. The priority of source i is `src_prio[i*PRIO_W +: PRIO_W]`.
- R6: If `ctl_rd` is high in the cycle after a source has won, the round is repeated, and `slot_inject` comes exactly one cycle later than it would otherwise.
- R7: The winner's flag reads 0 in the `slot_done` cycle. A new pulse for that same source during the `slot_inject` cycle is dropped. A pulse for another source in that cycle stays latched and is serviced later.
- R8: A `reti_done` pulse loads the holdoff count with HOLD_CYC, and `holdoff` is high while the count is nonzero. Each `instr_done` pulse lowers the count by one. No new round starts while the count is nonzero.
- R9: While `bus_busy` is high, the sequencer state and the holdoff count do not change, so a pending injection is delayed by the number of busy cycles.
- R10: Synchronous active-low reset clears all flags, returns the sequencer to idle and zeroes the holdoff count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_pulse | input | NSRC | Request pulses, one bit per source |
| src_en | input | NSRC | Source enable bits |
| src_prio | input | NSRC*PRIO_W | Packed priority levels |
| bus_busy | input | 1 | Bus wait or hold; stretches the current cycle |
| ctl_rd | input | 1 | The instruction in flight reads a channel control register |
| reti_done | input | 1 | A return-from-interrupt has executed |
| instr_done | input | 1 | One program instruction has completed |
| slot_inject | output | 1 | Transfer slot in decode; the next instruction is stalled |
| slot_done | output | 1 | The transfer completes and execution resumes |
| slot_src | output | IDX_W | Source index of the current slot |
| flags | output | NSRC | Pending request flags |
| holdoff | output | 1 | The post-return holdoff is active |

## Verification
Every internal state of this block shows up at the ports within a few cycles. A lost or stuck flag appears on `flags` one edge later. A wrong arbitration outcome appears as a wrong `slot_src` no more than three cycles after the request. A faulty state sequence moves `slot_inject` or `slot_done` off their exact cycles. Directed scenarios therefore sample on fixed cycles counted from the stimulus, so a one-cycle slip in latency, in the repeated round, in the busy freeze or in the holdoff release counts as a mismatch.

// File: rtl/xis_pkg.sv
// Shared types for the transfer injection sequencer.
package xis_pkg;
    // Sequencer phases: arbitrate, won, injected slot, completion.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WON  = 2'd1,
        ST_INJ  = 2'd2,
        ST_DONE = 2'd3
    } seq_st_t;
endpackage

// File: rtl/xis_arbiter.sv
// Combinational priority pick among candidate sources.
// Assumes: the candidate vector is already masked by flags and enables.
// Picks the highest level; on a tie the lower index wins.
module xis_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*PRIO_W-1:0] prio,
    output logic                   win_vld,
    output logic [IDX_W-1:0]       win_idx
);
    logic [PRIO_W-1:0] best;

    // Linear scan: a later source replaces the choice only when its level is strictly higher.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!win_vld || prio[i*PRIO_W +: PRIO_W] > best)) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
                best    = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/xis_holdoff.sv
// Post-return holdoff counter.
// Assumes: load and tick are single-cycle pulses. While freeze is high, nothing changes.
module xis_holdoff #(
    parameter int HOLD_CYC = 2,
    localparam int CNT_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic load,
    input  logic tick,
    output logic active
);
    logic [CNT_W-1:0] cnt;

    // Load on a return, count down on each completed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!freeze) begin
            if (load)
                cnt <= CNT_W'(HOLD_CYC);
            else if (tick && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);

    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HOLD_CYC));
    a_r9_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(cnt));
endmodule

// File: rtl/xis_flags.sv
// Sticky per-source request flags.
// Assumes: clr_en is already gated by the caller. A clear beats a set to the same bit.
module xis_flags #(
    parameter int NSRC   = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  set_vec,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0]  flags
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        // One flag bit: clear has precedence, otherwise a pulse sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (clr_en && clr_idx == IDX_W'(g))
                flags[g] <= 1'b0;
            else if (set_vec[g])
                flags[g] <= 1'b1;
        end

        a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_idx == IDX_W'(g)) |=> !flags[g]);
    end
endmodule

// File: rtl/xfer_inject_seq.sv
// Transfer injection sequencer top.
// Runs one arbitration round per cycle over flagged, enabled sources. It injects one
// transfer slot into decode, clears the winner's flag and then resumes execution.
// Assumes: ctl_rd is meaningful in the won cycle only; bus_busy stretches every cycle.
module xfer_inject_seq #(
    parameter int NSRC     = 8,
    parameter int PRIO_W   = 3,
    parameter int HOLD_CYC = 2,
    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        req_pulse,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic                   bus_busy,
    input  logic                   ctl_rd,
    input  logic                   reti_done,
    input  logic                   instr_done,
    output logic                   slot_inject,
    output logic                   slot_done,
    output logic [IDX_W-1:0]       slot_src,
    output logic [NSRC-1:0]        flags,
    output logic                   holdoff
);
    import xis_pkg::*;

    seq_st_t          st, st_nx;
    logic [IDX_W-1:0] cur_src, cur_nx;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic             clr_en;

    xis_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(req_pulse),
        .clr_en(clr_en), .clr_idx(cur_src), .flags(flags)
    );

    xis_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .cand(flags & src_en), .prio(src_prio),
        .win_vld(win_vld), .win_idx(win_idx)
    );

    xis_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .freeze(bus_busy),
        .load(reti_done), .tick(instr_done), .active(holdoff)
    );

    // Next-state choice: entry gated by holdoff; a control read repeats the won round.
    always_comb begin
        st_nx  = st;
        cur_nx = cur_src;
        unique case (st)
            ST_IDLE: if (!holdoff && win_vld) begin
                st_nx  = ST_WON;
                cur_nx = win_idx;
            end
            ST_WON: if (ctl_rd) begin
                if (win_vld) cur_nx = win_idx;
                else         st_nx  = ST_IDLE;
            end else begin
                st_nx = ST_INJ;
            end
            ST_INJ:  st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State and winner registers; bus_busy holds them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cur_src <= '0;
        end else if (!bus_busy) begin
            st      <= st_nx;
            cur_src <= cur_nx;
        end
    end

    assign clr_en      = (st == ST_INJ) && !bus_busy;
    assign slot_inject = (st == ST_INJ);
    assign slot_done   = (st == ST_DONE);
    assign slot_src    = cur_src;

    a_r2_won_to_inject: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WON && !bus_busy && !ctl_rd) |=> slot_inject);
    a_r3_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_inject && !bus_busy) |=> (slot_done && !slot_inject));
    a_r7_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_inject && !bus_busy) |=> !flags[$past(slot_src)]);
    a_r8_holdoff_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && holdoff) |=> st != ST_WON);
    a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> $stable(st) && $stable(slot_src));
endmodule

// File: tb/xfer_inject_seq_test.sv
module xfer_inject_seq_test;
    localparam int NS = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req_pulse = '0;
    logic [NS-1:0] src_en = '1;
    logic [NS*PW-1:0] src_prio = '0;
    logic          bus_busy = 1'b0;
    logic          ctl_rd = 1'b0;
    logic          reti_done = 1'b0;
    logic          instr_done = 1'b0;
    logic          slot_inject, slot_done, holdoff;
    logic [2:0]    slot_src;
    logic [NS-1:0] flags;

    int n_chk = 0;
    int n_bad = 0;

    xfer_inject_seq #(.NSRC(NS), .PRIO_W(PW), .HOLD_CYC(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .src_en(src_en),
        .src_prio(src_prio), .bus_busy(bus_busy), .ctl_rd(ctl_rd),
        .reti_done(reti_done), .instr_done(instr_done),
        .slot_inject(slot_inject), .slot_done(slot_done), .slot_src(slot_src),
        .flags(flags), .holdoff(holdoff)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        req_pulse = m;
        step();
        req_pulse = '0;
    endtask

    task automatic wait_inject(output int src);
        int n = 0;
        step();
        while (!slot_inject && n < 40) begin
            step();
            n++;
        end
        src = slot_inject ? int'(slot_src) : -1;
    endtask

    task automatic t_reset();
        check("R10 flags after reset", int'(flags), 0);
        check("R10 inject after reset", int'(slot_inject), 0);
        check("R10 done after reset", int'(slot_done), 0);
        check("R10 holdoff after reset", int'(holdoff), 0);
    endtask

    task automatic t_latency();
        pulse(8'h20);
        check("R1 flag set", int'(flags[5]), 1);
        check("R2 no inject in cycle 1", int'(slot_inject), 0);
        step();
        check("R2 no inject in cycle 2", int'(slot_inject), 0);
        step();
        check("R2 inject in cycle 3", int'(slot_inject), 1);
        check("R2 inject src", int'(slot_src), 5);
        step();
        check("R2 inject lasts one cycle", int'(slot_inject), 0);
        check("R3 done after inject", int'(slot_done), 1);
        check("R7 flag cleared in done", int'(flags[5]), 0);
        step();
        check("R3 done lasts one cycle", int'(slot_done), 0);
    endtask

    task automatic t_priority();
        int s;
        src_prio = '0;
        src_prio[2*PW +: PW] = 3'd3;
        src_prio[6*PW +: PW] = 3'd5;
        src_prio[1*PW +: PW] = 3'd5;
        pulse(8'h46);
        wait_inject(s); check("R5 tie to lower index", s, 1);
        wait_inject(s); check("R5 next highest", s, 6);
        wait_inject(s); check("R5 lowest last", s, 2);
        step();
        src_prio = '0;
    endtask

    task automatic t_enable();
        int seen = 0;
        int s;
        src_en = 8'hF7;
        pulse(8'h08);
        for (int i = 0; i < 6; i++) begin
            step();
            if (slot_inject) seen++;
        end
        check("R4 disabled source not served", seen, 0);
        check("R1 flag latched while disabled", int'(flags[3]), 1);
        src_en = '1;
        wait_inject(s);
        check("R4 served once enabled", s, 3);
        step();
    endtask

    task automatic t_ctl_read();
        pulse(8'h01);
        step();
        ctl_rd = 1'b1;
        step();
        ctl_rd = 1'b0;
        check("R6 no inject while round repeats", int'(slot_inject), 0);
        step();
        check("R6 inject one cycle later", int'(slot_inject), 1);
        check("R6 inject src", int'(slot_src), 0);
        step();
        step();
    endtask

    task automatic t_busy();
        int seen = 0;
        pulse(8'h10);
        step();
        bus_busy = 1'b1;
        step();
        seen += int'(slot_inject);
        step();
        seen += int'(slot_inject);
        step();
        seen += int'(slot_inject);
        bus_busy = 1'b0;
        check("R9 frozen while busy", seen, 0);
        step();
        check("R9 inject after busy ends", int'(slot_inject), 1);
        check("R9 inject src", int'(slot_src), 4);
        step();
        step();
    endtask

    task automatic t_holdoff();
        int seen = 0;
        reti_done = 1'b1;
        pulse(8'h80);
        reti_done = 1'b0;
        check("R8 holdoff active", int'(holdoff), 1);
        for (int i = 0; i < 4; i++) begin
            step();
            if (slot_inject) seen++;
        end
        check("R8 no entry during holdoff", seen, 0);
        instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        check("R8 holdoff after one instruction", int'(holdoff), 1);
        instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        check("R8 holdoff released after two", int'(holdoff), 0);
        step();
        check("R8 no inject yet", int'(slot_inject), 0);
        step();
        check("R8 inject after release", int'(slot_inject), 1);
        check("R8 inject src", int'(slot_src), 7);
        step();
        step();
    endtask

    task automatic t_overlap();
        int s;
        pulse(8'h02);
        step();
        step();
        check("R7 inject src 1", int'(slot_src), 1);
        req_pulse = 8'h06;
        step();
        req_pulse = '0;
        check("R7 same-source pulse dropped", int'(flags[1]), 0);
        check("R7 other source latched", int'(flags[2]), 1);
        wait_inject(s);
        check("R7 latched source served", s, 2);
        step();
        step();
        check("R7 all flags clear", int'(flags), 0);
    endtask

    task automatic t_reset_mid();
        reti_done = 1'b1;
        pulse(8'h21);
        reti_done = 1'b0;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        check("R10 flags cleared mid-run", int'(flags), 0);
        check("R10 holdoff cleared", int'(holdoff), 0);
        step();
        check("R10 idle after reset", int'(slot_inject), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_latency();
        t_priority();
        t_enable();
        t_ctl_read();
        t_busy();
        t_holdoff();
        t_overlap();
        t_reset_mid();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule